// File: doc/BRIEF.md
# Transmit Buffer Select Register

This block holds the choice of which of three transmit message buffers is mapped into a shared buffer access window. Software writes a mask of candidate buffers. The register keeps only the lowest-numbered bit that is set in that mask, so the stored selection is always one-hot or zero.

A useful consequence follows. Software can read the transmit-empty flag vector and write it back unchanged. The register then selects the first free buffer directly, and a read returns that single bit.

The block also decides whether a window access may proceed. The window is open only while a buffer is selected and that buffer's transmit-empty flag shows it is free. While the controller is in initialization mode, the register is forced to zero. While a mode change is under way, writes have no effect.

The CPU port is a plain single-cycle register port with no handshake. There is no data stream, so there is no back-pressure to define. The window request is a plain level, and the refuse output answers it in the same cycle.

Top module: `txbuf_select`

## Requirements
- R1: After reset the selection is zero: `sel_onehot` is 3'b000, `cpu_rd_data` is 8'h00 and `win_grant` is 0.
- R2: `cpu_rd_data[7:3]` always reads 0. `cpu_rd_data[2:0]` always equals the stored selection `sel_onehot`.
- R3: A write with `cpu_wr_en`=1 while `init_req`=0 and `init_ack`=0 stores, at the next rising edge, only the lowest set bit of `cpu_wr_data[2:0]`. Bit i stands for buffer i. For example, 3'b110 stores 3'b010 and 3'b011 stores 3'b001. `cpu_wr_data[7:3]` has no effect.
- R4: A permitted write of 3'b000 in `cpu_wr_data[2:0]` clears the selection. `win_grant` is then 0 from the next cycle.
- R5: While `init_req`=1 and `init_ack`=1, the selection is forced to 3'b000 at each rising edge, whatever is written.
- R6: While `init_req` and `init_ack` differ, writes are ignored and the selection keeps its value.
- R7: `win_grant` is combinational. It is 1 exactly when buffer i is selected and `tx_empty[i]`=1 (1 = buffer free). It is 0 when nothing is selected or when the selected buffer's flag is 0 (buffer queued for transmission).
- R8: `win_refuse` is combinational and equals `win_req` AND NOT `win_grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr_en | input | 1 | Register write strobe |
| cpu_wr_data | input | 8 | Written mask; only bits 2:0 are used |
| cpu_rd_data | output | 8 | Readback of the one-hot selection |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| tx_empty | input | 3 | Transmit-empty flags, bit i for buffer i, 1 = free |
| win_req | input | 1 | An access to the shared window is being attempted |
| sel_onehot | output | 3 | Stored one-hot selection |
| win_grant | output | 1 | Window access allowed |
| win_refuse | output | 1 | Window access attempted and refused |

## Verification
The lowest-set-bit rule is driven with all eight values of the low mask bits. This separates a correct priority picker from one that keeps the highest bit, keeps several bits, or ignores bit 0.

Each of those writes is paired with every pattern of the transmit-empty flags. That tells a grant tied to the selected buffer apart from one tied to any free buffer. The high mask bits are driven with nonzero values to show that they have no effect.

Writes are also made under each of the four request/acknowledge combinations. This shows the difference between forcing the register to zero in initialization mode, holding it during a mode change, and loading it in normal mode.

// File: rtl/txsel_pkg.sv
package txsel_pkg;
  parameter int TXSEL_NUM_BUF = 3;
  parameter int TXSEL_REG_W   = 8;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'b00,
    MODE_TRANSIT = 2'b01,
    MODE_INIT    = 2'b10
  } txsel_mode_e;

  function automatic txsel_mode_e decode_mode(input logic req, input logic ack);
    if (req && ack)        return MODE_INIT;
    else if (!req && !ack) return MODE_RUN;
    else                   return MODE_TRANSIT;
  endfunction
endpackage

// File: rtl/txsel_lowest_pick.sv
module txsel_lowest_pick #(
  parameter int WIDTH = txsel_pkg::TXSEL_NUM_BUF
) (
  input  logic [WIDTH-1:0] mask_in,
  output logic [WIDTH-1:0] pick_out
);
  logic [WIDTH:0] seen;

  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_chain
      assign pick_out[gi]  = mask_in[gi] & ~seen[gi];
      assign seen[gi+1]    = seen[gi] | mask_in[gi];
    end
  endgenerate

  always_comb begin
    assert ($onehot0(pick_out)); // R3
    assert ((mask_in == '0) == (pick_out == '0)); // R3
  end
endmodule

// File: rtl/txsel_reg.sv
module txsel_reg
  import txsel_pkg::*;
#(
  parameter int NUM_BUF = TXSEL_NUM_BUF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_BUF-1:0] wr_pick,
  input  logic               init_req,
  input  logic               init_ack,
  output logic [NUM_BUF-1:0] sel_q
);
  txsel_mode_e mode;

  assign mode = decode_mode(init_req, init_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      unique case (mode)
        MODE_INIT:    sel_q <= '0;
        MODE_RUN:     if (wr_en) sel_q <= wr_pick;
        default:      sel_q <= sel_q;
      endcase
    end
  end

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && init_ack) |=> (sel_q == '0)); // R5
  AST_TRANSIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req != init_ack) |=> $stable(sel_q)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(init_req && init_ack)) |=> $stable(sel_q)); // R3
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q)); // R3
endmodule

// File: rtl/txsel_window_gate.sv
module txsel_window_gate #(
  parameter int NUM_BUF = txsel_pkg::TXSEL_NUM_BUF
) (
  input  logic [NUM_BUF-1:0] sel,
  input  logic [NUM_BUF-1:0] tx_empty,
  input  logic               win_req,
  output logic               win_grant,
  output logic               win_refuse
);
  logic [NUM_BUF-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_BUF; gi++) begin : g_hit
      assign hit[gi] = sel[gi] & tx_empty[gi];
    end
  endgenerate

  assign win_grant  = |hit;
  assign win_refuse = win_req & ~win_grant;

  always_comb begin
    if (sel == '0) assert (!win_grant); // R7
    if (win_req)   assert (win_grant ^ win_refuse); // R8
  end
endmodule

// File: rtl/txbuf_select.sv
module txbuf_select
  import txsel_pkg::*;
#(
  parameter int NUM_BUF = TXSEL_NUM_BUF,
  parameter int REG_W   = TXSEL_REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr_en,
  input  logic [REG_W-1:0]   cpu_wr_data,
  output logic [REG_W-1:0]   cpu_rd_data,
  input  logic               init_req,
  input  logic               init_ack,
  input  logic [NUM_BUF-1:0] tx_empty,
  input  logic               win_req,
  output logic [NUM_BUF-1:0] sel_onehot,
  output logic               win_grant,
  output logic               win_refuse
);
  localparam int PAD_W = REG_W - NUM_BUF;

  logic [NUM_BUF-1:0] wr_pick;

  txsel_lowest_pick #(.WIDTH(NUM_BUF)) u_pick (
    .mask_in  (cpu_wr_data[NUM_BUF-1:0]),
    .pick_out (wr_pick)
  );

  txsel_reg #(.NUM_BUF(NUM_BUF)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cpu_wr_en),
    .wr_pick  (wr_pick),
    .init_req (init_req),
    .init_ack (init_ack),
    .sel_q    (sel_onehot)
  );

  txsel_window_gate #(.NUM_BUF(NUM_BUF)) u_gate (
    .sel        (sel_onehot),
    .tx_empty   (tx_empty),
    .win_req    (win_req),
    .win_grant  (win_grant),
    .win_refuse (win_refuse)
  );

  assign cpu_rd_data = {{PAD_W{1'b0}}, sel_onehot};

  AST_DESELECT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && !init_req && !init_ack && cpu_wr_data[NUM_BUF-1:0] == '0)
    |=> !win_grant); // R4
  AST_BIT0_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_en && !init_req && !init_ack && cpu_wr_data[0])
    |=> (cpu_rd_data == REG_W'(1))); // R3
  AST_GRANT_FREE_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    win_grant |-> ((sel_onehot & tx_empty) != '0)); // R7
endmodule

// File: tb/txbuf_select_bench.sv
module txbuf_select_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr_en = 1'b0;
  logic [7:0] cpu_wr_data = '0;
  logic [7:0] cpu_rd_data;
  logic       init_req = 1'b0;
  logic       init_ack = 1'b0;
  logic [2:0] tx_empty = '0;
  logic       win_req = 1'b0;
  logic [2:0] sel_onehot;
  logic       win_grant;
  logic       win_refuse;

  int n_tests = 0;
  int n_fail  = 0;
  int model_sel = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  txbuf_select u_txbuf_select (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_data(cpu_rd_data), .init_req(init_req), .init_ack(init_ack),
    .tx_empty(tx_empty), .win_req(win_req), .sel_onehot(sel_onehot),
    .win_grant(win_grant), .win_refuse(win_refuse)
  );

  function automatic int lowest_bit(input int v);
    for (int b = 0; b < 3; b++) if (v[b]) return (1 << b);
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs(input string tag);
    int exp_grant;
    exp_grant = ((model_sel & int'(tx_empty)) != 0) ? 1 : 0;
    check({"R2 ", tag}, int'(cpu_rd_data), model_sel);
    check({"R2 sel ", tag}, int'(sel_onehot), model_sel);
    check({"R7 ", tag}, int'(win_grant), exp_grant);
    check({"R8 ", tag}, int'(win_refuse), (win_req && exp_grant == 0) ? 1 : 0);
  endtask

  task automatic step(input bit wr, input logic [7:0] data, input bit rq, input bit ak,
                      input logic [2:0] emp, input bit acc, input string tag);
    @(negedge clk);
    cpu_wr_en = wr; cpu_wr_data = data; init_req = rq; init_ack = ak;
    tx_empty = emp; win_req = acc;
    #1 check_outputs(tag);
    @(posedge clk);
    if (rq && ak) model_sel = 0;
    else if (wr && !rq && !ak) model_sel = lowest_bit(int'(data[2:0]));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tx_empty = 3'b111; win_req = 1'b1;
    #1;
    check("R1 reset sel", int'(sel_onehot), 0);
    check("R1 reset rd", int'(cpu_rd_data), 0);
    check("R1 reset grant", int'(win_grant), 0);
    rst_n = 1'b1;

    // R3 R7 R8 R2: every low mask with every flag pattern, high bits noisy
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 8; e++) begin
        step(1'b1, 8'(((m + e) << 3) | m), 1'b0, 1'b0, 3'(e), e[0], "R3 sweep");
        step(1'b0, 8'hFF, 1'b0, 1'b0, 3'(e), 1'b1, "R3 after write");
        step(1'b0, 8'h00, 1'b0, 1'b0, 3'(~e), 1'b1, "R7 flags flipped");
      end
    end

    // R3 worked examples
    step(1'b1, 8'b0000_0110, 1'b0, 1'b0, 3'b110, 1'b1, "R3 0x06");
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'b110, 1'b1, "R3 0x06 reads 0x02");
    step(1'b1, 8'b0000_0011, 1'b0, 1'b0, 3'b000, 1'b1, "R3 0x03");
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'b001, 1'b1, "R3 0x03 reads 0x01");

    // R4 deselect
    step(1'b1, 8'b0000_0100, 1'b0, 1'b0, 3'b111, 1'b1, "R4 select 2");
    step(1'b1, 8'b1111_1000, 1'b0, 1'b0, 3'b111, 1'b1, "R4 write zero");
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'b111, 1'b1, "R4 grant low");

    // R6 transitional modes hold
    step(1'b1, 8'b0000_0010, 1'b0, 1'b0, 3'b111, 1'b0, "R6 setup");
    step(1'b1, 8'b0000_0001, 1'b1, 1'b0, 3'b111, 1'b0, "R6 req only");
    step(1'b1, 8'b0000_0100, 1'b0, 1'b1, 3'b111, 1'b0, "R6 ack only");
    step(1'b1, 8'b0000_0000, 1'b1, 1'b0, 3'b111, 1'b1, "R6 zero ignored");
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'b111, 1'b1, "R6 held");

    // R5 init mode clears and blocks writes
    step(1'b0, 8'h00, 1'b1, 1'b1, 3'b111, 1'b1, "R5 enter init");
    step(1'b1, 8'b0000_0001, 1'b1, 1'b1, 3'b111, 1'b1, "R5 write in init");
    step(1'b1, 8'b0000_0100, 1'b1, 1'b1, 3'b111, 1'b1, "R5 still zero");
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'b111, 1'b1, "R5 leave init");
    step(1'b1, 8'b0000_0100, 1'b0, 1'b0, 3'b011, 1'b1, "R7 select 2 busy");
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'b011, 1'b1, "R7 busy refused");
    step(1'b0, 8'h00, 1'b0, 1'b0, 3'b100, 1'b0, "R8 no request");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule